// File: doc/BRIEF.md
# Asynchronous Static Memory Controller

This block turns single requests from an internal port into timed accesses on an external bus for asynchronous parts such as SRAM and NOR flash. A request carries an address, write data, byte enables, a direction flag and a region code. The controller runs the access through three timed phases: setup, strobe and hold. It finishes with a one-cycle done pulse, which also carries the read data captured from the bus.

Three chip-select regions each keep their own configuration word. The word holds separate phase counts for reads and for writes, a strobe-only select flag and an enable for wait stretching. The configuration is sampled when a request is accepted, so a later configuration write never disturbs an access that is already running. An external WAIT input passes through a two-flop synchronizer. When enabled, it freezes the strobe phase, and a wait limit ends the access if WAIT never releases.

Top module: `asram_ctrl`

## Requirements
- R1: After reset every chip select, write enable and output enable is high, all byte-enable pins are high, the data bus is not driven, `req_ready` is 1 and `rsp_done` is 0. Every region then uses zero phase counts, full-access select mode and ignores WAIT, so an access lasts 3 cycles with a 1-cycle strobe.
- R2: A configuration word is written through `cfg_we`/`cfg_idx`/`cfg_wdata` with this layout: write setup [3:0], write strobe [7:4], write hold [11:8], read setup [15:12], read strobe [19:16], read hold [23:20], strobe-only select [24], wait enable [25]. Each phase lasts its count plus one cycle, and the read or write counts are chosen by the access direction.
- R3: When bit 24 is clear, the region's chip select is low from the first setup cycle to the last hold cycle.
- R4: When bit 24 is set, the region's chip select is low only during the strobe cycles.
- R5: Region codes 0, 1 and 2 drive `mem_cs_n[0]`, `[1]` and `[2]`. No other chip select moves during an access.
- R6: `mem_oe_n` is low only during the strobe of a read, and `mem_we_n` is low only during the strobe of a write.
- R7: During an access `mem_dqm_n` equals the inverted request byte enables, for both reads and writes.
- R8: The data bus is driven (`mem_dq_oe` = 1), carrying the write data, from the first setup cycle to the last hold cycle of a write, and never during a read.
- R9: Read data is sampled on the last strobe cycle and appears on `rsp_rdata` with `rsp_done`. `rsp_done` is a single-cycle pulse in the cycle after the last hold cycle.
- R10: With bit 25 set, a synchronized high WAIT holds the strobe phase. With bit 25 clear, WAIT has no effect on the strobe length.
- R11: If WAIT holds the strobe for `MAX_WAIT` cycles, the strobe ends after exactly `MAX_WAIT` cycles and `rsp_timeout` is 1 together with `rsp_done`.
- R12: `mem_ba` carries `req_addr[1:0]` and `mem_a` carries the remaining upper address bits. Both stay stable for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Region whose configuration word is written |
| cfg_wdata | input | 26 | Configuration word |
| req_valid | input | 1 | Request present; taken when `req_ready` is 1 |
| req_ready | output | 1 | Controller idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_region | input | 2 | Chip-select region code, 0 to 2 |
| req_addr | input | ADDR_W+2 | Request address, bank bits at the bottom |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, active high |
| rsp_done | output | 1 | Access finished, one cycle |
| rsp_rdata | output | DATA_W | Captured read data |
| rsp_timeout | output | 1 | Access ended by the wait limit |
| mem_cs_n | output | NUM_CS | Chip selects, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dqm_n | output | DATA_W/8 | Byte enables, active low |
| mem_ba | output | 2 | Bank address |
| mem_a | output | ADDR_W | Address |
| mem_dq_o | output | DATA_W | Data bus output value |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_dq_i | input | DATA_W | Data bus input value |
| mem_wait | input | 1 | External wait, asynchronous |

## Verification
The assertions assume that `req_valid` is raised only while `req_ready` is high and that `req_region` never carries code 3. The bench obeys both rules: its driver waits for the previous access to finish and complete its check before it issues the next request, and it uses only the codes 0 to 2. WAIT is treated as asynchronous, and the assertions make no claim about how long it lasts. For that reason the bench checks a stretched strobe only against bounds, and it checks exact lengths only when WAIT is steady or disabled.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int CNT_W = 4;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    // Packed from the top bit down: bit 0 is wr_setup[0]
    typedef struct packed {
        logic             wait_en;
        logic             strobe_sel;
        logic [CNT_W-1:0] rd_hold;
        logic [CNT_W-1:0] rd_strobe;
        logic [CNT_W-1:0] rd_setup;
        logic [CNT_W-1:0] wr_hold;
        logic [CNT_W-1:0] wr_strobe;
        logic [CNT_W-1:0] wr_setup;
    } region_cfg_t;

    localparam int CFG_W = $bits(region_cfg_t);

endpackage

// File: rtl/asram_wait_sync.sv
module asram_wait_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [1:0] stage_d, stage_q;

    always_comb begin
        stage_d = {stage_q[0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_o = stage_q[1];
endmodule

// File: rtl/asram_cfg_bank.sv
module asram_cfg_bank
    import asram_pkg::*;
#(
    parameter int NUM_CS = 3,
    localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output region_cfg_t       cfg_o [NUM_CS]
);
    region_cfg_t cfg_d [NUM_CS];
    region_cfg_t cfg_q [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_region
        always_comb begin
            cfg_d[g] = cfg_q[g];
            if (cfg_we && (cfg_idx == IDX_W'(g))) cfg_d[g] = region_cfg_t'(cfg_wdata);
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cfg_q[g] <= '0;
            else        cfg_q[g] <= cfg_d[g];
        end

        assign cfg_o[g] = cfg_q[g];
    end
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int REQ_AW   = 24,
    parameter int DATA_W   = 32,
    parameter int NUM_CS   = 3,
    parameter int MAX_WAIT = 64,
    localparam int BE_W    = DATA_W / 8,
    localparam int IDX_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int WCNT_W  = (MAX_WAIT > 2) ? $clog2(MAX_WAIT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_region,
    input  logic [REQ_AW-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    input  region_cfg_t       sel_cfg,
    input  logic              wait_s,
    input  logic [DATA_W-1:0] dq_in,
    output phase_e            phase_o,
    output logic              write_o,
    output logic [IDX_W-1:0]  region_o,
    output logic              strobe_sel_o,
    output logic [REQ_AW-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [BE_W-1:0]   be_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic              tmo_o
);
    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [WCNT_W-1:0] wcnt;
        logic              write;
        logic [IDX_W-1:0]  region;
        region_cfg_t       cfg;
        logic [REQ_AW-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic              tmo;
    } seq_t;

    seq_t s_d, s_q;

    logic [CNT_W-1:0] strobe_cnt, hold_cnt;

    always_comb begin
        strobe_cnt = s_q.write ? s_q.cfg.wr_strobe : s_q.cfg.rd_strobe;
        hold_cnt   = s_q.write ? s_q.cfg.wr_hold   : s_q.cfg.rd_hold;
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.phase  = PH_SETUP;
                    s_d.write  = req_write;
                    s_d.region = req_region;
                    s_d.cfg    = sel_cfg;
                    s_d.addr   = req_addr;
                    s_d.wdata  = req_wdata;
                    s_d.be     = req_be;
                    s_d.tmo    = 1'b0;
                    s_d.wcnt   = '0;
                    s_d.cnt    = req_write ? sel_cfg.wr_setup : sel_cfg.rd_setup;
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_STROBE;
                    s_d.cnt   = strobe_cnt;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (s_q.cfg.wait_en && wait_s) begin
                    if (s_q.wcnt == WCNT_W'(MAX_WAIT - 1)) begin
                        s_d.tmo   = 1'b1;
                        s_d.phase = PH_HOLD;
                        s_d.cnt   = hold_cnt;
                        if (!s_q.write) s_d.rdata = dq_in;
                    end else begin
                        s_d.wcnt = s_q.wcnt + 1'b1;
                    end
                end else if (s_q.cnt == '0) begin
                    s_d.phase = PH_HOLD;
                    s_d.cnt   = hold_cnt;
                    if (!s_q.write) s_d.rdata = dq_in;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o      = s_q.phase;
    assign write_o      = s_q.write;
    assign region_o     = s_q.region;
    assign strobe_sel_o = s_q.cfg.strobe_sel;
    assign addr_o       = s_q.addr;
    assign wdata_o      = s_q.wdata;
    assign be_o         = s_q.be;
    assign rdata_o      = s_q.rdata;
    assign done_o       = s_q.done;
    assign tmo_o        = s_q.tmo;
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int DATA_W   = 32,
    parameter int NUM_CS   = 3,
    parameter int MAX_WAIT = 64,
    localparam int REQ_AW  = ADDR_W + 2,
    localparam int BE_W    = DATA_W / 8,
    localparam int IDX_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_region,
    input  logic [REQ_AW-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_timeout,
    output logic [NUM_CS-1:0] mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [BE_W-1:0]   mem_dqm_n,
    output logic [1:0]        mem_ba,
    output logic [ADDR_W-1:0] mem_a,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i,
    input  logic              mem_wait
);
    region_cfg_t       cfg_all [NUM_CS];
    region_cfg_t       sel_cfg;
    logic              wait_s;
    phase_e            phase;
    logic              acc_write, acc_strobe_sel, acc_done, acc_tmo;
    logic [IDX_W-1:0]  acc_region;
    logic [REQ_AW-1:0] acc_addr;
    logic [DATA_W-1:0] acc_wdata;
    logic [BE_W-1:0]   acc_be;
    logic              busy, in_strobe;

    asram_cfg_bank #(.NUM_CS(NUM_CS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_o     (cfg_all)
    );

    asram_wait_sync u_wsync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (mem_wait),
        .sync_o  (wait_s)
    );

    always_comb begin
        sel_cfg = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (req_region == IDX_W'(i)) sel_cfg = cfg_all[i];
        end
    end

    asram_seq #(
        .REQ_AW   (REQ_AW),
        .DATA_W   (DATA_W),
        .NUM_CS   (NUM_CS),
        .MAX_WAIT (MAX_WAIT)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_region   (req_region),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_be       (req_be),
        .sel_cfg      (sel_cfg),
        .wait_s       (wait_s),
        .dq_in        (mem_dq_i),
        .phase_o      (phase),
        .write_o      (acc_write),
        .region_o     (acc_region),
        .strobe_sel_o (acc_strobe_sel),
        .addr_o       (acc_addr),
        .wdata_o      (acc_wdata),
        .be_o         (acc_be),
        .rdata_o      (rsp_rdata),
        .done_o       (acc_done),
        .tmo_o        (acc_tmo)
    );

    assign busy      = (phase != PH_IDLE);
    assign in_strobe = (phase == PH_STROBE);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign mem_cs_n[g] = !(busy && (acc_region == IDX_W'(g)) &&
                               (!acc_strobe_sel || in_strobe));
    end

    assign req_ready   = !busy;
    assign rsp_done    = acc_done;
    assign rsp_timeout = acc_done && acc_tmo;
    assign mem_we_n    = !(in_strobe && acc_write);
    assign mem_oe_n    = !(in_strobe && !acc_write);
    assign mem_dqm_n   = busy ? ~acc_be : '1;
    assign mem_dq_oe   = busy && acc_write;
    assign mem_dq_o    = acc_wdata;
    assign mem_ba      = acc_addr[1:0];
    assign mem_a       = acc_addr[REQ_AW-1:2];
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int NUM_CS = 3,
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              rsp_timeout,
    input logic [NUM_CS-1:0] mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe,
    input logic [1:0]        mem_ba,
    input logic [ADDR_W-1:0] mem_a
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    p_one_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    p_bus_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

    p_tmo_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_timeout |-> rsp_done);

    p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> ($stable(mem_a) && $stable(mem_ba)));
endmodule

bind asram_ctrl asram_ctrl_chk #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .rsp_timeout (rsp_timeout),
    .mem_cs_n    (mem_cs_n),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_dq_oe   (mem_dq_oe),
    .mem_ba      (mem_ba),
    .mem_a       (mem_a)
);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;
    localparam int ADDR_W   = 22;
    localparam int DATA_W   = 32;
    localparam int NUM_CS   = 3;
    localparam int MAX_WAIT = 64;
    localparam int BE_W     = DATA_W / 8;
    localparam int REQ_AW   = ADDR_W + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_idx = '0;
    logic [25:0]       cfg_wdata = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [1:0]        req_region = '0;
    logic [REQ_AW-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [BE_W-1:0]   req_be = '0;
    logic              rsp_done;
    logic [DATA_W-1:0] rsp_rdata;
    logic              rsp_timeout;
    logic [NUM_CS-1:0] mem_cs_n;
    logic              mem_we_n, mem_oe_n, mem_dq_oe;
    logic [BE_W-1:0]   mem_dqm_n;
    logic [1:0]        mem_ba;
    logic [ADDR_W-1:0] mem_a;
    logic [DATA_W-1:0] mem_dq_o, mem_dq_i;
    logic              mem_wait = 1'b0;

    always #2.5 clk = ~clk;

    asram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS), .MAX_WAIT(MAX_WAIT))
    u_asram_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_region(req_region), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dqm_n(mem_dqm_n),
        .mem_ba(mem_ba), .mem_a(mem_a), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i), .mem_wait(mem_wait)
    );

    // Memory model: returns an address-derived pattern only while output enable is low
    function automatic logic [DATA_W-1:0] rd_model(input logic [ADDR_W-1:0] a);
        return {a[15:0] ^ 16'hA5C3, ~a[15:0]};
    endfunction
    assign mem_dq_i = mem_oe_n ? 32'h0BAD_F00D : rd_model(mem_a);

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Bench copy of each region's settings
    int sh_ws[3], sh_wt[3], sh_wh[3], sh_rs[3], sh_rt[3], sh_rh[3];
    bit sh_ss[3], sh_ew[3];

    task automatic set_cfg(input int idx, input bit ew, input bit ss,
                           input int rs, input int rt, input int rh,
                           input int ws, input int wt, input int wh);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_idx   = 2'(idx);
        cfg_wdata = {ew, ss, 4'(rh), 4'(rt), 4'(rs), 4'(wh), 4'(wt), 4'(ws)};
        sh_ws[idx] = ws; sh_wt[idx] = wt; sh_wh[idx] = wh;
        sh_rs[idx] = rs; sh_rt[idx] = rt; sh_rh[idx] = rh;
        sh_ss[idx] = ss; sh_ew[idx] = ew;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    typedef struct {
        int                region;
        bit                write;
        logic [REQ_AW-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
        bit                ss;
        int                sh_sum;
        bit                exact;
        int                stb_len;
        bit                tmo;
    } exp_t;

    exp_t exp_q[$];

    // mode: 0 = strobe exact, 1 = stretched by WAIT, 2 = held to the wait limit
    task automatic access(input int region, input bit write, input logic [REQ_AW-1:0] addr,
                          input logic [DATA_W-1:0] data, input logic [BE_W-1:0] be,
                          input int mode);
        exp_t e;
        e.region = region; e.write = write; e.addr = addr; e.data = data; e.be = be;
        e.ss     = sh_ss[region];
        e.sh_sum = write ? (sh_ws[region] + sh_wh[region] + 2) : (sh_rs[region] + sh_rh[region] + 2);
        e.stb_len = write ? (sh_wt[region] + 1) : (sh_rt[region] + 1);
        e.exact  = (mode != 1);
        e.tmo    = (mode == 2);
        if (mode == 2) e.stb_len = MAX_WAIT;
        while (!req_ready) @(negedge clk);
        exp_q.push_back(e);
        req_valid = 1'b1; req_write = write; req_region = 2'(region);
        req_addr = addr; req_wdata = data; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor / scoreboard
    int cs_cnt[3];
    int we_cnt = 0, oe_cnt = 0, dqoe_cnt = 0;
    logic [DATA_W-1:0] cap_data;
    logic [BE_W-1:0]   cap_dqm;
    logic [REQ_AW-1:0] cap_addr;

    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 3; i++) if (!mem_cs_n[i]) cs_cnt[i] = cs_cnt[i] + 1;
            if (!mem_we_n) begin
                we_cnt++; cap_data = mem_dq_o; cap_dqm = mem_dqm_n; cap_addr = {mem_a, mem_ba};
            end
            if (!mem_oe_n) begin
                oe_cnt++; cap_dqm = mem_dqm_n; cap_addr = {mem_a, mem_ba};
            end
            if (mem_dq_oe) dqoe_cnt++;
            if (rsp_done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "done without request", 1, 0);
                end else begin
                    exp_t e;
                    int stb, other, exp_cs;
                    e = exp_q.pop_front();
                    stb = e.write ? we_cnt : oe_cnt;
                    if (e.exact)
                        chk(stb == e.stb_len, e.tmo ? "R11" : "R2", "strobe cycles", stb, e.stb_len);
                    else
                        chk(stb > e.stb_len && stb < MAX_WAIT, "R10", "stretched strobe", stb, e.stb_len);
                    exp_cs = e.ss ? stb : e.sh_sum + stb;
                    chk(cs_cnt[e.region] == exp_cs, e.ss ? "R4" : "R3", "select cycles",
                        cs_cnt[e.region], exp_cs);
                    other = 0;
                    for (int i = 0; i < 3; i++) if (i != e.region) other += cs_cnt[i];
                    chk(other == 0, "R5", "other select cycles", other, 0);
                    chk((e.write ? oe_cnt : we_cnt) == 0, "R6", "wrong strobe cycles",
                        e.write ? oe_cnt : we_cnt, 0);
                    chk(cap_dqm == ~e.be, "R7", "byte enable pins", cap_dqm, ~e.be);
                    chk(dqoe_cnt == (e.write ? e.sh_sum + stb : 0), "R8", "bus drive cycles",
                        dqoe_cnt, e.write ? e.sh_sum + stb : 0);
                    chk(cap_addr == e.addr, "R12", "address pins", cap_addr, e.addr);
                    if (e.write)
                        chk(cap_data == e.data, "R8", "write data", cap_data, e.data);
                    else
                        chk(rsp_rdata == rd_model(e.addr[REQ_AW-1:2]), "R9", "read data",
                            rsp_rdata, rd_model(e.addr[REQ_AW-1:2]));
                    chk(rsp_timeout == e.tmo, "R11", "timeout flag", rsp_timeout, e.tmo);
                end
                for (int i = 0; i < 3; i++) cs_cnt[i] = 0;
                we_cnt = 0; oe_cnt = 0; dqoe_cnt = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            sh_ws[i] = 0; sh_wt[i] = 0; sh_wh[i] = 0; sh_rs[i] = 0; sh_rt[i] = 0; sh_rh[i] = 0;
            sh_ss[i] = 0; sh_ew[i] = 0; cs_cnt[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle pins after reset
        chk(mem_cs_n == 3'b111, "R1", "chip selects", mem_cs_n, 3'b111);
        chk(mem_we_n && mem_oe_n, "R1", "strobes", {mem_we_n, mem_oe_n}, 2'b11);
        chk(mem_dqm_n == '1 && !mem_dq_oe, "R1", "dqm/bus", {mem_dqm_n, mem_dq_oe}, 5'b11110);
        chk(req_ready && !rsp_done, "R1", "ready/done", {req_ready, rsp_done}, 2'b10);

        // R1: default region settings, 3-cycle access
        access(1, 1'b0, 24'h00_1234, '0, 4'b1111, 0); drain();
        access(1, 1'b1, 24'h3F_0002, 32'hCAFE_0001, 4'b0101, 0); drain();

        // R2 R3: full-access select, separate read/write counts
        set_cfg(0, 1'b0, 1'b0, 1, 2, 0, 2, 3, 1);
        access(0, 1'b1, 24'h12_3457, 32'h1122_3344, 4'b1001, 0); drain();
        access(0, 1'b0, 24'h12_3457, '0, 4'b0110, 0); drain();

        // R4: strobe-only select
        set_cfg(2, 1'b0, 1'b1, 3, 0, 1, 0, 4, 2);
        access(2, 1'b1, 24'hAB_CDE1, 32'hDEAD_BEEF, 4'b1111, 0); drain();
        access(2, 1'b0, 24'h00_FFFE, '0, 4'b0011, 0); drain();

        // R10: WAIT ignored when disabled for the region
        mem_wait = 1'b1;
        access(0, 1'b0, 24'h55_AA03, '0, 4'b1100, 0); drain();

        // R10: WAIT stretches the strobe when enabled
        set_cfg(1, 1'b1, 1'b0, 0, 1, 1, 1, 2, 1);
        access(1, 1'b1, 24'h0F_0F0C, 32'h8765_4321, 4'b1110, 1);
        repeat (8) @(negedge clk);
        mem_wait = 1'b0;
        drain();

        // R11: WAIT held to the limit
        mem_wait = 1'b1;
        repeat (3) @(negedge clk);
        access(1, 1'b0, 24'h21_4365, '0, 4'b0001, 2); drain();
        mem_wait = 1'b0;
        repeat (4) @(negedge clk);

        // Back-to-back mixed traffic
        access(1, 1'b0, 24'h7F_FFFF, '0, 4'b1000, 0); drain();
        access(2, 1'b1, 24'h40_0000, 32'h0000_FFFF, 4'b0100, 0); drain();
        access(0, 1'b0, 24'h01_0203, '0, 4'b1111, 0); drain();

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule